// File: doc/BRIEF.md
# Write-Only Serial Word Transmitter

This block turns parallel words into a serial stream for a device that only listens. An upstream source presents a word together with a write strobe; the block sends the word one bit at a time on a data line and drives a serial clock beside it. The downstream device latches each bit on the rising edge of that serial clock.

All registers run on the single system clock. The serial clock is produced by counters and clock-enable logic and leaves the block as a plain output; nothing inside is clocked by it. A wait output tells the source when a word offered this cycle cannot be taken. The wait output drops in the final system cycle of a word, so a source that keeps the strobe high streams words with no gap in the serial clock. If no word is waiting at that point, the block goes idle with both lines low.

Top module: `spi_word_tx`

## Requirements
- R1: A synchronous active-high reset forces idle: serial clock 0, data line 0, wait 0. It acts on the next system clock edge, also in the middle of a word.
- R2: During a word, each bit period lasts 2*HALF_CYC system cycles (38 by default). The serial clock is high for the first HALF_CYC cycles and low for the last HALF_CYC cycles.
- R3: Bits leave least significant bit first. Bit n (value WORD_W'(word) >> n & 1) is on the data line for the whole of bit period n.
- R4: The data line changes only in the cycle in which the serial clock rises, so it is stable throughout every high phase.
- R5: In the system cycle after the edge that accepts a word, the serial clock is 1 and the data line holds bit 0 of the word.
- R6: The wait output is 1 in every busy cycle except the last cycle of the last bit period. In that cycle, and in idle, it is 0.
- R7: A write sampled while wait is 0 in the last cycle of a word starts the next word at once. The serial clock is high in the very next cycle, with no gap.
- R8: With no write in the last cycle of a word, the block returns to idle. The serial clock and data line are 0, wait is 0, and both lines stay 0 while no write arrives.
- R9: A write strobe raised while wait is 1 is ignored. The word in flight continues unchanged and the offered word is never sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_i | input | 1 | Write strobe; taken on an edge where wait_o is 0 |
| wdata_i | input | WORD_W | Word to send, valid with wr_i |
| wait_o | output | 1 | 1 when a word offered this cycle cannot be accepted |
| sclk_o | output | 1 | Divided serial clock, low in idle |
| sdo_o | output | 1 | Serial data, least significant bit first |

## Verification
A write accepted on edge E shows its effect one cycle later. Cycle k after E (k = 0 .. 8*38-1) must show the serial clock at (k mod 38) < 19 and the data line at bit k/38. Wait must be low only at k = 303. The bench drives inputs and samples outputs on the falling edge, counts k from the acceptance edge, and checks every cycle of every word. A reset or a stop shows one cycle after the edge that samples it, and the bench checks at that falling edge.

// File: rtl/spi_word_tx_pkg.sv
package spi_word_tx_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } tx_state_e;
endpackage

// File: rtl/spi_tx_ctrl.sv
module spi_tx_ctrl
  import spi_word_tx_pkg::*;
#(
  parameter int WORD_W   = 8,
  parameter int HALF_CYC = 19
) (
  input  logic clk,
  input  logic rst,
  input  logic wr,
  output logic ev_load,
  output logic ev_bit,
  output logic ev_last,
  output logic ev_stop,
  output logic busy,
  output logic sclk
);
  localparam int PERIOD = 2 * HALF_CYC;
  localparam int PH_W   = $clog2(PERIOD);
  localparam int BIT_W  = (WORD_W > 1) ? $clog2(WORD_W) : 1;

  tx_state_e        state;
  logic [PH_W-1:0]  ph;
  logic [BIT_W-1:0] bc;

  function automatic logic [PH_W-1:0] ph_reload();
    return PH_W'(PERIOD - 1);
  endfunction

  function automatic logic [BIT_W-1:0] bc_reload();
    return BIT_W'(WORD_W - 1);
  endfunction

  function automatic logic at_fall(input logic [PH_W-1:0] p);
    return p == PH_W'(HALF_CYC);
  endfunction

  assign busy    = (state == ST_SEND);
  assign ev_last = busy && (ph == '0) && (bc == '0);
  assign ev_bit  = busy && (ph == '0) && (bc != '0);
  assign ev_load = wr && (!busy || ev_last);
  assign ev_stop = ev_last && !wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      ph    <= '0;
      bc    <= '0;
      sclk  <= 1'b0;
    end else if (ev_load) begin
      state <= ST_SEND;
      ph    <= ph_reload();
      bc    <= bc_reload();
      sclk  <= 1'b1;
    end else if (ev_stop) begin
      state <= ST_IDLE;
      ph    <= '0;
      bc    <= '0;
      sclk  <= 1'b0;
    end else if (busy) begin
      if (ev_bit) begin
        ph   <= ph_reload();
        bc   <= bc - 1'b1;
        sclk <= 1'b1;
      end else begin
        ph <= ph - 1'b1;
        if (at_fall(ph)) sclk <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              adv,
  input  logic              clr,
  input  logic [WORD_W-1:0] din,
  output logic              sdo
);
  logic [WORD_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst || clr)  sh <= '0;
    else if (load)   sh <= din;
    else if (adv)    sh <= sh >> 1;
  end

  assign sdo = sh[0];
endmodule

// File: rtl/spi_word_tx.sv
module spi_word_tx #(
  parameter int WORD_W   = 8,
  parameter int HALF_CYC = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic              wait_o,
  output logic              sclk_o,
  output logic              sdo_o
);
  logic ev_load, ev_bit, ev_last, ev_stop, st_busy;

  spi_tx_ctrl #(.WORD_W(WORD_W), .HALF_CYC(HALF_CYC)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr      (wr_i),
    .ev_load (ev_load),
    .ev_bit  (ev_bit),
    .ev_last (ev_last),
    .ev_stop (ev_stop),
    .busy    (st_busy),
    .sclk    (sclk_o)
  );

  spi_tx_shift #(.WORD_W(WORD_W)) u_shift (
    .clk  (clk),
    .rst  (rst),
    .load (ev_load),
    .adv  (ev_bit),
    .clr  (ev_stop),
    .din  (wdata_i),
    .sdo  (sdo_o)
  );

  assign wait_o = st_busy && !ev_last;
endmodule

// File: rtl/spi_word_tx_chk.sv
module spi_word_tx_chk #(
  parameter int HALF_CYC = 19
) (
  input logic clk,
  input logic rst,
  input logic wd_lsb,
  input logic wait_o,
  input logic sclk_o,
  input logic sdo_o,
  input logic ev_load,
  input logic ev_bit,
  input logic ev_last,
  input logic st_busy
);
  localparam int CW = $clog2(HALF_CYC + 2);
  logic [CW-1:0] hi_cnt, lo_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt <= '0;
      lo_cnt <= '0;
    end else begin
      hi_cnt <= sclk_o ? hi_cnt + 1'b1 : '0;
      lo_cnt <= (!sclk_o && st_busy) ? lo_cnt + 1'b1 : '0;
    end
  end

  p_idle_low_r8: assert property (@(posedge clk) disable iff (rst)
    !st_busy |-> (!sclk_o && !sdo_o && !wait_o));

  p_load_first_bit_r5: assert property (@(posedge clk) disable iff (rst)
    ev_load |=> (sclk_o && (sdo_o == $past(wd_lsb))));

  p_data_stable_r4: assert property (@(posedge clk) disable iff (rst)
    (sclk_o && $past(sclk_o)) |-> $stable(sdo_o));

  p_wait_busy_r6: assert property (@(posedge clk) disable iff (rst)
    (st_busy && !ev_last) |-> wait_o);

  p_high_len_r2: assert property (@(posedge clk) disable iff (rst)
    hi_cnt <= CW'(HALF_CYC));

  p_low_len_r2: assert property (@(posedge clk) disable iff (rst)
    lo_cnt <= CW'(HALF_CYC));

  p_rise_cause_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk_o) |-> $past(ev_load || ev_bit));
endmodule

bind spi_word_tx spi_word_tx_chk #(.HALF_CYC(HALF_CYC)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wd_lsb  (wdata_i[0]),
  .wait_o  (wait_o),
  .sclk_o  (sclk_o),
  .sdo_o   (sdo_o),
  .ev_load (ev_load),
  .ev_bit  (ev_bit),
  .ev_last (ev_last),
  .st_busy (st_busy)
);

// File: tb/sim_spi_word_tx.sv
module sim_spi_word_tx;
  localparam int W   = 8;
  localparam int H   = 19;
  localparam int P   = 2 * H;
  localparam int LEN = W * P;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr  = 1'b0;
  logic [W-1:0] wd = '0;
  logic wt, sclk, sdo;
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  spi_word_tx #(.WORD_W(W), .HALF_CYC(H)) u0 (
    .clk(clk), .rst(rst), .wr_i(wr), .wdata_i(wd),
    .wait_o(wt), .sclk_o(sclk), .sdo_o(sdo)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // One word already accepted; walk its LEN cycles. nxt/nd set the strobe
  // in the last cycle; poke raises a write mid-word (must be ignored, R9).
  task automatic run_word(input logic [W-1:0] d, input bit nxt,
                          input logic [W-1:0] nd, input bit poke);
    int bad_clk = 0, bad_dat = 0, bad_wt = 0;
    for (int k = 0; k < LEN; k++) begin
      @(negedge clk);
      if (sclk !== ((k % P) < H)) bad_clk++;
      if (sdo !== d[k / P]) bad_dat++;
      if (wt !== (k != LEN - 1)) bad_wt++;
      if (poke && k == 100) begin wr = 1'b1; wd = ~d; end
      if (poke && k == 101) wr = 1'b0;
      if (k == LEN - 1) begin wr = nxt; wd = nd; end
    end
    chk(bad_clk == 0, "R2 clock period/duty", bad_clk, 0);
    chk(bad_dat == 0, "R3/R4 lsb-first stable data", bad_dat, 0);
    chk(bad_wt == 0, "R6 wait pattern", bad_wt, 0);
    if (poke) chk(bad_dat == 0, "R9 write while busy ignored", bad_dat, 0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    chk(sclk === 1'b0 && sdo === 1'b0 && wt === 1'b0, "R1 reset state", {sclk, sdo, wt}, 0);
    rst = 1'b0;
    // R8: idle holds with no write
    repeat (10) @(negedge clk);
    chk(sclk === 1'b0 && sdo === 1'b0, "R8 idle stays low", {sclk, sdo}, 0);
    // Gapless stream of every word value (R7 at each boundary)
    wr = 1'b1; wd = '0;
    for (int v = 0; v < 256; v++) begin
      if (v > 0) begin
        // first cycle of word v: clock must already be high (no gap)
        // checked inside run_word at k=0; also record explicitly
      end
      run_word(W'(v), v < 255, W'(v + 1), 1'b0);
      if (v < 255) begin
        @(negedge clk);
        chk(sclk === 1'b1 && sdo === (((v + 1) & 1) != 0), "R7 gapless next word / R5", {sclk, sdo}, {1'b1, 1'(v + 1)});
        // the k=0 cycle was consumed; walk remaining via fresh word run
        // realign: run_word expects to start at k=0, so re-check from k=1
        begin
          int bad = 0;
          for (int k = 1; k < LEN; k++) begin
            if (k > 1 || 1) ;
            @(negedge clk);
            if (sclk !== ((k % P) < H) || sdo !== 1'((v + 1) >> (k / P)) || wt !== (k != LEN - 1)) bad++;
            if (k == LEN - 1) begin wr = (v + 1 < 255); wd = W'(v + 2); end
          end
          chk(bad == 0, "R2/R3/R6 streamed word", bad, 0);
        end
        v++;
      end
    end
    // Stop: strobe low in last cycle
    @(negedge clk);
    chk(sclk === 1'b0 && sdo === 1'b0 && wt === 1'b0, "R8 clean stop", {sclk, sdo, wt}, 0);
    repeat (20) @(negedge clk);
    chk(sclk === 1'b0 && sdo === 1'b0, "R8 idle after stop", {sclk, sdo}, 0);
    // Single word with ignored mid-word write, then stop
    wr = 1'b1; wd = 8'hA5;
    run_word(8'hA5, 1'b0, '0, 1'b1);
    @(negedge clk);
    chk(sclk === 1'b0 && sdo === 1'b0 && wt === 1'b0, "R9 offered word not sent", {sclk, sdo, wt}, 0);
    repeat (P) @(negedge clk);
    chk(sclk === 1'b0 && sdo === 1'b0, "R9 no late start", {sclk, sdo}, 0);
    // Reset mid-word
    wr = 1'b1; wd = 8'hFF;
    @(negedge clk); wr = 1'b0;
    repeat (5) @(negedge clk);
    chk(sclk === 1'b1 && sdo === 1'b1 && wt === 1'b1, "R5 word started before reset", {sclk, sdo, wt}, 7);
    rst = 1'b1;
    @(negedge clk);
    chk(sclk === 1'b0 && sdo === 1'b0 && wt === 1'b0, "R1 reset mid-word", {sclk, sdo, wt}, 0);
    rst = 1'b0;
    repeat (P) @(negedge clk);
    chk(sclk === 1'b0 && sdo === 1'b0, "R1 idle after reset", {sclk, sdo}, 0);
    done = 1'b1;
    summary();
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 190000);
      summary();
    end
  end
endmodule